// File: doc/BRIEF.md
# Dual-Edge Loadable Up/Down Counter

This block is a binary counter of configurable width that changes its value on both the rising and the falling edge of one clock, so it advances twice per clock period. An active-high asynchronous clear forces the count to zero at once. A synchronous load copies a parallel data word into the count. Two separate enables, one for counting up and one for counting down, set the direction. When both are high, counting up wins.

Two terminal flags show that the count sits at all ones (up) or at all zeros (down). Two cascade outputs gate those flags with the matching enable, so one stage can enable the next stage of a wider chained counter. Inside, the counter keeps one register bank for each clock edge and forms the visible count as the XOR of the two banks. Every flop is therefore an ordinary single-edge flop.

Top module: `dual_edge_updown_counter`

## Requirements
- R1: While `clr` is high, `count` is all zeros within the same clock phase, with no clock edge needed, and it stays zero across clock edges whatever the other inputs are. Clear overrides load and counting. Holding `clr` high at power-up leaves the count at zero.
- R2: With `clr` low and `load` high, `count` takes `din` on every rising edge and on every falling edge, whatever `up_en` and `dn_en` are.
- R3: With `clr` and `load` low and both enables low, `count` keeps its value across both edge types, and `cas_up` and `cas_dn` are both 0.
- R4: With `clr` and `load` low, `up_en` high and `dn_en` low, `count` rises by one on each rising edge and on each falling edge.
- R5: With `clr` and `load` low, `up_en` low and `dn_en` high, `count` falls by one on each rising edge and on each falling edge.
- R6: With `clr` and `load` low and both enables high, `count` rises by one on each edge. The cascade outputs carry no defined meaning in this case.
- R7: `tc_up` is 1 exactly when every bit of `count` is 1, and `tc_dn` is 1 exactly when every bit of `count` is 0.
- R8: `cas_up` equals `tc_up` AND `up_en`, and `cas_dn` equals `tc_dn` AND `dn_en`, whenever both enables are not high together.
- R9: Counting up from all ones gives all zeros, and counting down from all zeros gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges update the count |
| clr | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Parallel load request, active high |
| up_en | input | 1 | Count-up enable |
| dn_en | input | 1 | Count-down enable |
| din | input | WIDTH | Parallel load word |
| count | output | WIDTH | Current count value |
| tc_up | output | 1 | Count is all ones |
| tc_dn | output | 1 | Count is all zeros |
| cas_up | output | 1 | Up cascade enable for the next stage |
| cas_dn | output | 1 | Down cascade enable for the next stage |

## Verification
The bench builds the counter with the default WIDTH of 4. At this width each direction wraps after sixteen edges, which is eight clock periods. A short directed run can therefore pass both terminal values, in both directions, on rising edges and on falling edges. The narrow word also lets a reference model check every edge, including loads applied on opposite edge types and a clear raised and dropped in the middle of a clock phase.

// File: rtl/dedc_pkg.sv
package dedc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;

    // Load beats counting; up beats down when both are requested.
    function automatic cnt_op_e decode_op(input logic load, input logic up, input logic dn);
        if (load)    return OP_LOAD;
        else if (up) return OP_INC;
        else if (dn) return OP_DEC;
        else         return OP_HOLD;
    endfunction

endpackage

// File: rtl/dedc_next.sv
module dedc_next
    import dedc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dedc_edge_bank.sv
module dedc_edge_bank #(
    parameter int WIDTH  = 4,
    parameter bit RISING = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] nxt,
    input  logic [WIDTH-1:0] other,
    output logic [WIDTH-1:0] q
);
    // The bank stores nxt XOR other, so that q XOR other equals nxt
    // right after this bank's edge.
    generate
        if (RISING) begin : g_rise
            always_ff @(posedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= nxt ^ other;
            end
        end else begin : g_fall
            always_ff @(negedge clk or posedge clr) begin
                if (clr) q <= '0;
                else     q <= nxt ^ other;
            end
        end
    endgenerate
endmodule

// File: rtl/dedc_flags.sv
module dedc_flags #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_en,
    input  logic             dn_en,
    output logic             tc_up,
    output logic             tc_dn,
    output logic             cas_up,
    output logic             cas_dn
);
    always_comb begin
        tc_up  = &count;
        tc_dn  = ~|count;
        cas_up = tc_up & up_en;
        cas_dn = tc_dn & dn_en;
    end
endmodule

// File: rtl/dual_edge_updown_counter.sv
module dual_edge_updown_counter
    import dedc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc_up,
    output logic             tc_dn,
    output logic             cas_up,
    output logic             cas_dn
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] bank_r;
    logic [WIDTH-1:0] bank_f;

    assign op    = decode_op(load, up_en, dn_en);
    assign count = bank_r ^ bank_f;

    dedc_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (count),
        .din (din),
        .nxt (nxt)
    );

    dedc_edge_bank #(.WIDTH(WIDTH), .RISING(1'b1)) u_bank_r (
        .clk   (clk),
        .clr   (clr),
        .nxt   (nxt),
        .other (bank_f),
        .q     (bank_r)
    );

    dedc_edge_bank #(.WIDTH(WIDTH), .RISING(1'b0)) u_bank_f (
        .clk   (clk),
        .clr   (clr),
        .nxt   (nxt),
        .other (bank_r),
        .q     (bank_f)
    );

    dedc_flags #(.WIDTH(WIDTH)) u_flags (
        .count  (count),
        .up_en  (up_en),
        .dn_en  (dn_en),
        .tc_up  (tc_up),
        .tc_dn  (tc_dn),
        .cas_up (cas_up),
        .cas_dn (cas_dn)
    );

    // Checker state: the inputs and count seen at one edge type, compared
    // at the opposite edge. A clear empties the snapshot at once.
    logic             sr_vld, sf_vld;
    logic             sr_ld,  sf_ld;
    logic             sr_up,  sf_up;
    logic             sr_dn,  sf_dn;
    logic [WIDTH-1:0] sr_cnt, sf_cnt;
    logic [WIDTH-1:0] sr_din, sf_din;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            sr_vld <= 1'b0; sr_ld <= 1'b0; sr_up <= 1'b0; sr_dn <= 1'b0;
            sr_cnt <= '0;   sr_din <= '0;
        end else begin
            sr_vld <= 1'b1; sr_ld <= load; sr_up <= up_en; sr_dn <= dn_en;
            sr_cnt <= count; sr_din <= din;
        end
    end

    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            sf_vld <= 1'b0; sf_ld <= 1'b0; sf_up <= 1'b0; sf_dn <= 1'b0;
            sf_cnt <= '0;   sf_din <= '0;
        end else begin
            sf_vld <= 1'b1; sf_ld <= load; sf_up <= up_en; sf_dn <= dn_en;
            sf_cnt <= count; sf_din <= din;
        end
    end

    a_r2_load_on_rise: assert property (@(negedge clk) disable iff (clr)
        (sr_vld && sr_ld) |-> (count == sr_din));
    a_r2_load_on_fall: assert property (@(posedge clk) disable iff (clr)
        (sf_vld && sf_ld) |-> (count == sf_din));
    a_r3_hold_on_rise: assert property (@(negedge clk) disable iff (clr)
        (sr_vld && !sr_ld && !sr_up && !sr_dn) |-> (count == sr_cnt));
    a_r3_hold_on_fall: assert property (@(posedge clk) disable iff (clr)
        (sf_vld && !sf_ld && !sf_up && !sf_dn) |-> (count == sf_cnt));
    // R6: up wins over down, so these also cover both enables high.
    a_r4_inc_on_rise: assert property (@(negedge clk) disable iff (clr)
        (sr_vld && !sr_ld && sr_up) |-> (count == sr_cnt + ONE));
    a_r4_inc_on_fall: assert property (@(posedge clk) disable iff (clr)
        (sf_vld && !sf_ld && sf_up) |-> (count == sf_cnt + ONE));
    a_r5_dec_on_rise: assert property (@(negedge clk) disable iff (clr)
        (sr_vld && !sr_ld && !sr_up && sr_dn) |-> (count == sr_cnt - ONE));
    a_r5_dec_on_fall: assert property (@(posedge clk) disable iff (clr)
        (sf_vld && !sf_ld && !sf_up && sf_dn) |-> (count == sf_cnt - ONE));
endmodule

// File: tb/dual_edge_updown_counter_tb_top.sv
module dual_edge_updown_counter_tb_top;
    localparam int W = 4;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         load = 1'b0;
    logic         up_en = 1'b0;
    logic         dn_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc_up, tc_dn, cas_up, cas_dn;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_cnt = '0;

    dual_edge_updown_counter #(.WIDTH(W)) dut_i (
        .clk(clk), .clr(clr), .load(load), .up_en(up_en), .dn_en(dn_en),
        .din(din), .count(count), .tc_up(tc_up), .tc_dn(tc_dn),
        .cas_up(cas_up), .cas_dn(cas_dn)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Count and flags against the model; cascades only when defined (R8).
    task automatic chk_all(input string req);
        chk(req, "count", int'(count), int'(exp_cnt));
        chk("R7", "tc_up", int'(tc_up), int'(exp_cnt == ALL1));
        chk("R7", "tc_dn", int'(tc_dn), int'(exp_cnt == '0));
        if (!(up_en && dn_en)) begin
            chk("R8", "cas_up", int'(cas_up), int'((exp_cnt == ALL1) && up_en));
            chk("R8", "cas_dn", int'(cas_dn), int'((exp_cnt == '0) && dn_en));
        end
    endtask

    // Wait for the next edge of either type, update the model, sample 2 ns later.
    task automatic edge_step(input string req);
        @(clk);
        if (clr)        exp_cnt = '0;
        else if (load)  exp_cnt = din;
        else if (up_en) exp_cnt = exp_cnt + 1'b1;
        else if (dn_en) exp_cnt = exp_cnt - 1'b1;
        #2;
        chk_all(req);
    endtask

    task automatic t_reset;
        clr = 1'b1; load = 1'b1; up_en = 1'b1; din = 4'd9;
        edge_step("R1");
        edge_step("R1");
        load = 1'b0; up_en = 1'b0;
        clr = 1'b0;
    endtask

    task automatic t_load;
        load = 1'b1; up_en = 1'b1; dn_en = 1'b1; din = 4'hA;
        @(posedge clk); #2;
        exp_cnt = 4'hA; chk_all("R2");
        din = 4'h5;
        @(negedge clk); #2;
        exp_cnt = 4'h5; chk_all("R2");
        din = 4'h3;
        edge_step("R2");
        load = 1'b0; up_en = 1'b0; dn_en = 1'b0;
    endtask

    task automatic t_hold;
        din = 4'hC;
        for (int i = 0; i < 4; i++) begin
            edge_step("R3");
            chk("R3", "cas_up", int'(cas_up), 0);
            chk("R3", "cas_dn", int'(cas_dn), 0);
        end
    endtask

    task automatic t_up;
        up_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            edge_step("R4");
            if (exp_cnt == '0) chk("R9", "wrap_up", int'(count), 0);
        end
        up_en = 1'b0;
    endtask

    task automatic t_down;
        dn_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            edge_step("R5");
            if (exp_cnt == ALL1) chk("R9", "wrap_dn", int'(count), int'(ALL1));
        end
        dn_en = 1'b0;
    endtask

    task automatic t_both;
        up_en = 1'b1; dn_en = 1'b1;
        for (int i = 0; i < 6; i++) edge_step("R6");
        up_en = 1'b0; dn_en = 1'b0;
    endtask

    task automatic t_midclear;
        up_en = 1'b1;
        edge_step("R4");
        edge_step("R4");
        #1 clr = 1'b1;
        #0.5;
        exp_cnt = '0;
        chk_all("R1");
        @(clk); #2;
        chk_all("R1");
        clr = 1'b0;
        for (int i = 0; i < 3; i++) edge_step("R4");
        up_en = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        exp_cnt = '0;
        chk_all("R1");
        t_reset();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_both();
        t_midclear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule